// File: doc/BRIEF.md
# Combining-Tree Barrier with Sense Reversal

This block makes a group of `NUM_PART` participants meet at a common point before any of them goes on. Each participant pulses its arrive input once per episode. The arrivals are gathered by a tree of small counting nodes, each with `FANIN` inputs. A node counts its inputs down from the number of live children. When the count reaches zero, the node sends one pulse to its parent and reloads for the next episode. The child that goes up is therefore fixed by position, tournament style, and no single counter sees all `NUM_PART` arrivals.

When the root node completes, a go pulse travels back down a pipeline whose length is the tree depth. The pulse reaches every participant in the same cycle. A global sense bit toggles together with the go pulse. A participant can either watch its go strobe, or compare the sense bit with its own local copy. The block runs episode after episode without any reset step.

If a participant arrives a second time before it has been released, that arrival is flagged on an error output and is not counted. Leaf positions beyond `NUM_PART`, which exist when `NUM_PART` is not a power of `FANIN`, are removed from their parent's count, so they behave as if they had already arrived.

Top module: `comb_barrier`

## Requirements
- R1: After reset, `go_o`, `sense_o` and `dup_err_o` are all 0, and no participant is pending.
- R2: `go_o` never pulses until every one of the `NUM_PART` participants has made a counted arrival in the current episode.
- R3: With depth L = ceil(log base `FANIN` of `NUM_PART`), and L at least 1, `go_o` rises on all bits together 2L-1 clock edges after the edge that samples the last arrival. It stays high for exactly one cycle. With the defaults (6 participants, fan-in 2), L = 3 and the delay is 5 edges.
- R4: `sense_o` toggles on the same edge on which `go_o` rises, and at no other time.
- R5: An arrival from a participant that is already pending sets that participant's `dup_err_o` bit for one cycle, one edge later. The arrival is not counted, so it cannot complete the episode on behalf of an absent participant.
- R6: Arrivals combine correctly whether they come all in the same cycle, one at a time, or in any order.
- R7: A new episode can begin in the cycle right after `go_o` is seen, with no reset. Every node has reloaded its count.
- R8: An arrival sampled on the same edge that raises `go_o` comes from a participant that is still pending. It is treated as a duplicate under R5 and does not join the next episode.
- R9: Leaf positions at index `NUM_PART` and above do not hold the barrier back. Only the real participants are needed to complete an episode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arrive_i | input | NUM_PART | One-cycle arrival strobe per participant |
| go_o | output | NUM_PART | One-cycle release strobe per participant (all bits equal) |
| sense_o | output | 1 | Global sense, toggles on each completed episode |
| dup_err_o | output | NUM_PART | One-cycle flag for a duplicate arrival, per participant |

## Verification
The node assertion that no count underflows depends on the entry stage: a participant must add at most one counted pulse per episode. The release assertion relies on pending state being cleared only on the edge that raises `go_o`. The stimulus drives arrival pulses one cycle wide, away from the sampling edge. Repeat arrivals happen only after a participant has seen `go_o`, except in the cases that deliberately test duplicates, and those include an arrival timed onto the release edge. A behavioural model of the pending set, the release delay and the sense bit is checked against the outputs in every cycle.

// File: rtl/cbar_pkg.sv
package cbar_pkg;

  function automatic int ipow(input int base, input int ex);
    int r;
    r = 1;
    for (int i = 0; i < ex; i++) r = r * base;
    return r;
  endfunction

  // number of tree levels needed so that fanin**levels >= parts (at least 1)
  function automatic int tree_levels(input int parts, input int fanin);
    int lv;
    int span;
    lv = 1;
    span = fanin;
    while (span < parts) begin
      span = span * fanin;
      lv++;
    end
    return lv;
  endfunction

  // bit offset of level k in the flattened arrival vector
  function automatic int lvl_off(input int k, input int fanin, input int levels);
    int s;
    s = 0;
    for (int m = 0; m < k; m++) s = s + ipow(fanin, levels - m);
    return s;
  endfunction

  // children of node j at level k that cover at least one real participant
  function automatic int live_children(input int k, input int j, input int fanin, input int parts);
    int n;
    int span;
    n = 0;
    span = ipow(fanin, k);
    for (int c = 0; c < fanin; c++)
      if ((j * fanin + c) * span < parts) n++;
    return n;
  endfunction

endpackage

// File: rtl/cbar_node.sv
module cbar_node #(
  parameter int FANIN  = 2,
  parameter int RELOAD = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [FANIN-1:0] child_i,
  output logic             done_o
);
  localparam int CW = $clog2(FANIN + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] hits;
  logic [CW-1:0] rem;

  assign hits = CW'($countones(child_i));
  assign rem  = cnt - hits;

  // fetch-and-decrement; the last arriver fires upward and the count reloads
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= CW'(RELOAD);
      done_o <= 1'b0;
    end else if ((|child_i) && (rem == '0)) begin
      cnt    <= CW'(RELOAD);
      done_o <= 1'b1;
    end else begin
      cnt    <= rem;
      done_o <= 1'b0;
    end
  end

  // R6: simultaneous arrivals never exceed what is still owed at this node
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (rst)
    hits <= cnt);

endmodule

// File: rtl/cbar_entry.sv
module cbar_entry #(
  parameter int NUM_PART = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PART-1:0] arrive_i,
  input  logic                clear_i,
  output logic [NUM_PART-1:0] accept_o,
  output logic [NUM_PART-1:0] pend_o,
  output logic [NUM_PART-1:0] dup_o
);
  assign accept_o = arrive_i & ~pend_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o <= '0;
      dup_o  <= '0;
    end else begin
      dup_o  <= arrive_i & pend_o;
      pend_o <= clear_i ? '0 : (pend_o | accept_o);
    end
  end

  // R5: a duplicate flag only follows an arrival from a pending participant
  a_r5_dup_needs_pending: assert property (@(posedge clk) disable iff (rst)
    (dup_o & ~$past(pend_o)) == '0);

endmodule

// File: rtl/cbar_release.sv
module cbar_release #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic root_i,
  output logic pre_go_o,
  output logic go_o,
  output logic sense_o
);
  logic [DEPTH-1:0] stg;

  generate
    if (DEPTH == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= root_i;
      end
      assign pre_go_o = root_i;
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= {stg[DEPTH-2:0], root_i};
      end
      assign pre_go_o = stg[DEPTH-2];
    end
  endgenerate

  assign go_o = stg[DEPTH-1];

  always_ff @(posedge clk) begin
    if (rst) sense_o <= 1'b0;
    else     sense_o <= sense_o ^ pre_go_o;
  end

  // R4: each release comes with a sense flip
  a_r4_sense_flips: assert property (@(posedge clk) disable iff (rst)
    go_o |-> (sense_o != $past(sense_o)));
  // R3: the release is a single-cycle strobe
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    go_o |=> !go_o);

endmodule

// File: rtl/comb_barrier.sv
module comb_barrier #(
  parameter int NUM_PART = 6,
  parameter int FANIN    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PART-1:0] arrive_i,
  output logic [NUM_PART-1:0] go_o,
  output logic                sense_o,
  output logic [NUM_PART-1:0] dup_err_o
);
  import cbar_pkg::*;

  localparam int LEVELS = tree_levels(NUM_PART, FANIN);
  localparam int LEAVES = ipow(FANIN, LEVELS);
  localparam int TOT    = lvl_off(LEVELS + 1, FANIN, LEVELS);
  localparam int ROOT   = lvl_off(LEVELS, FANIN, LEVELS);

  logic [NUM_PART-1:0] accept;
  logic [NUM_PART-1:0] pend;
  logic [TOT-1:0]      up;
  logic                pre_go;
  logic                go_all;

  cbar_entry #(.NUM_PART(NUM_PART)) u_entry (
    .clk      (clk),
    .rst      (rst),
    .arrive_i (arrive_i),
    .clear_i  (pre_go),
    .accept_o (accept),
    .pend_o   (pend),
    .dup_o    (dup_err_o)
  );

  // leaf positions; unused ones never pulse and are absent from parent counts (R9)
  generate
    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
      if (i < NUM_PART) begin : g_real
        assign up[i] = accept[i];
      end else begin : g_tied
        assign up[i] = 1'b0;
      end
    end

    for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
      localparam int NK  = ipow(FANIN, LEVELS - 1 - k);
      localparam int OIN = lvl_off(k, FANIN, LEVELS);
      localparam int OUT = lvl_off(k + 1, FANIN, LEVELS);
      for (genvar j = 0; j < NK; j++) begin : g_node
        cbar_node #(
          .FANIN  (FANIN),
          .RELOAD (live_children(k, j, FANIN, NUM_PART))
        ) u_node (
          .clk     (clk),
          .rst     (rst),
          .child_i (up[OIN + j*FANIN +: FANIN]),
          .done_o  (up[OUT + j])
        );
      end
    end
  endgenerate

  cbar_release #(.DEPTH(LEVELS)) u_rel (
    .clk      (clk),
    .rst      (rst),
    .root_i   (up[ROOT]),
    .pre_go_o (pre_go),
    .go_o     (go_all),
    .sense_o  (sense_o)
  );

  assign go_o = {NUM_PART{go_all}};

  // R2: a release implies every participant was pending just before it
  a_r2_release_needs_all: assert property (@(posedge clk) disable iff (rst)
    go_all |-> (&$past(pend)));

endmodule

// File: tb/tb_comb_barrier.sv
module tb_comb_barrier;
  localparam int P = 6;
  localparam int F = 2;

  function automatic int depth_of(input int p, input int f);
    int d;
    int reach;
    d = 1;
    reach = f;
    while (reach < p) begin
      reach = reach * f;
      d = d + 1;
    end
    return d;
  endfunction

  localparam int LAT = 2 * depth_of(P, F) - 1;
  localparam logic [P-1:0] ALL = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [P-1:0] arrive = '0;
  logic [P-1:0] go;
  logic         sense;
  logic [P-1:0] dup;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2 clk = ~clk;

  comb_barrier #(.NUM_PART(P), .FANIN(F)) dut (
    .clk       (clk),
    .rst       (rst),
    .arrive_i  (arrive),
    .go_o      (go),
    .sense_o   (sense),
    .dup_err_o (dup)
  );

  // behavioural reference model
  logic [P-1:0] mpend = '0;
  logic [P-1:0] macc;
  logic         msense = 1'b0;
  logic         exp_go = 1'b0;
  logic [P-1:0] exp_err = '0;
  int           tmr = 0;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst) begin
      mpend = '0; msense = 1'b0; exp_go = 1'b0; exp_err = '0; tmr = 0;
    end else begin
      exp_err = arrive & mpend;
      macc    = arrive & ~mpend;
      mpend   = mpend | macc;
      exp_go  = 1'b0;
      if (tmr > 0) begin
        tmr = tmr - 1;
        if (tmr == 0) begin
          exp_go = 1'b1;
          msense = ~msense;
          mpend  = '0;
        end
      end else if (macc != '0 && mpend == ALL) begin
        tmr = LAT;
      end
    end
    if (cyc > 20000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired: actual cycles %0d expected below 20000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      checks = checks + 1;
      if (go !== {P{exp_go}} || sense !== msense || dup !== exp_err) begin
        fails = fails + 1;
        $display("FAIL R2 R3 R4 R5 model compare: actual go=%b sense=%b dup=%b expected go=%b sense=%b dup=%b",
                 go, sense, dup, {P{exp_go}}, msense, exp_err);
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive a one-cycle arrival; returns at the first negedge after it was sampled
  task automatic send(input logic [P-1:0] m);
    @(negedge clk) arrive = m;
    @(negedge clk) arrive = '0;
  endtask

  // counts negedges (this one included) until go is seen
  task automatic wait_go(output int n);
    n = 1;
    while (go[0] !== 1'b1 && n < 60) begin
      @(negedge clk);
      n = n + 1;
    end
  endtask

  int n;
  logic s0;

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(go == '0, "R1 go after reset", int'(go), 0);
    chk(sense == 1'b0, "R1 sense after reset", int'(sense), 0);
    chk(dup == '0, "R1 dup after reset", int'(dup), 0);

    // R6 R9 all arrive together; tied leaves do not block
    send(ALL);
    wait_go(n);
    chk(n == LAT + 1, "R3 R9 latency all-at-once", n, LAT + 1);
    chk(go == ALL, "R3 all go bits together", int'(go), int'(ALL));
    chk(sense == 1'b1, "R4 sense after first release", int'(sense), 1);
    @(negedge clk);
    chk(go == '0, "R3 go single cycle", int'(go), 0);

    // R6 staggered arrivals, R2 no early release, R5 duplicate not counted
    send(6'b010101);
    repeat (8) @(negedge clk);
    chk(go == '0, "R2 no release with half arrived", int'(go), 0);
    send(6'b000001);
    chk(dup == 6'b000001, "R5 dup flag for repeat arrival", int'(dup), 1);
    send(6'b001010);
    repeat (8) @(negedge clk);
    chk(go == '0, "R5 duplicate did not stand in for absent one", int'(go), 0);
    send(6'b100000);
    wait_go(n);
    chk(n == LAT + 1, "R3 latency staggered last arrival", n, LAT + 1);
    chk(sense == 1'b0, "R4 sense toggles back", int'(sense), 0);

    // R7 back-to-back reuse, reverse order arrivals
    send(6'b110000);
    send(6'b001100);
    send(6'b000011);
    wait_go(n);
    chk(n == LAT + 1, "R7 immediate reuse latency", n, LAT + 1);
    chk(sense == 1'b1, "R7 sense after reuse", int'(sense), 1);

    // R8 arrival on the release edge counts as a duplicate
    send(ALL);
    repeat (LAT - 1) @(negedge clk);
    arrive = 6'b000001;
    @(negedge clk) arrive = '0;
    chk(go == ALL, "R8 release on expected edge", int'(go), int'(ALL));
    chk(dup == 6'b000001, "R8 arrival at release edge flagged", int'(dup), 1);
    s0 = sense;
    send(6'b111110);
    repeat (10) @(negedge clk);
    chk(go == '0 && sense == s0, "R8 early arrival did not join next episode", int'(go), 0);
    send(6'b000001);
    wait_go(n);
    chk(n == LAT + 1, "R8 R9 episode completes once participant 0 arrives", n, LAT + 1);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule